// File: doc/BRIEF.md
# Multi-Bank Row State Controller

This block follows the open or closed state of four DRAM banks and judges every command on the command pins against that state. It decodes the strobes on each rising clock edge. It keeps one state machine and one countdown timer per bank, and it remembers the row held open in each bank. Every bank command is reported as either accepted or rejected. An accepted read or write is also passed on as a decoded column access.

A memory controller, or a protocol monitor next to one, uses the block to keep its commands consistent with bank state. Two delays are enforced per bank: the activate-to-column delay and the close-to-reopen recovery. A read or write can ask for the bank to close by itself. The bank then stays open for the length of the burst, which a 2-bit setting selects. After that it shuts and starts its recovery time with no further command.

Top module: `bank_row_ctl`

## Requirements
- R1: After synchronous reset every bank is closed, every stored row is zero, and `cmd_ok`, `cmd_bad` and `col_valid` are low.
- R2: A command sampled with `cs_n` high has no effect. It raises no flag, produces no column access and changes no bank state.
- R3: The pins {cs_n, ras_n, cas_n, we_n} are decoded as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0111 no-op, 0001 refresh, 0000 mode set. A bank command raises exactly one of `cmd_ok` or `cmd_bad` in the cycle after its sampling edge. An accepted activate opens the bank chosen by `bank` and stores `addr` (13 bits) as that bank's row.
- R4: An accepted read or write drives `col_valid` for one cycle, with the following fields: `col_bank` is the target bank, `col_addr` is {addr[11], addr[9:0]}, `col_write` is 1 for a write and 0 for a read, and `col_autopre` is addr[10].
- R5: An accepted precharge with addr[10]=1 closes every open bank. It is accepted only when no bank has a running timer or a pending self-close.
- R6: An accepted precharge with addr[10]=0 closes only the bank named by `bank`. All other banks keep their state.
- R7: A read or write reaching a bank fewer than T_RCD (default 3) rising edges after its activate is rejected. At exactly T_RCD edges it is accepted.
- R8: An activate reaching a bank fewer than T_RP (default 3) edges after that bank closed is rejected. At exactly T_RP edges it is accepted.
- R9: A read or write with addr[10]=1 keeps the bank open for B clocks and closes it on the B-th edge after the command. B is 1 for `burst_sel` 00 or 01 (2 beats), 2 for 10 (4 beats) and 4 for 11 (8 beats). The T_RP recovery runs from that closing edge.
- R10: The following are rejected and leave bank state and stored rows unchanged: a read or write to a closed bank, an activate to an open bank, and any bank command to a bank whose timer is running or whose self-close is pending.
- R11: No-op, refresh and mode set raise neither flag and change no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Bank address |
| addr | input | 13 | Row, column, and auto-close / all-banks bit 10 |
| burst_sel | input | 2 | Burst length select for self-close timing |
| bank_open | output | 4 | One bit per bank, high while the bank holds a row |
| open_row | output | 52 | Stored row per bank, bank i at bits [13i+12:13i] |
| cmd_ok | output | 1 | Previous bank command was accepted |
| cmd_bad | output | 1 | Previous bank command was rejected |
| col_valid | output | 1 | Decoded column access this cycle |
| col_write | output | 1 | Column access is a write |
| col_bank | output | 2 | Bank of the column access |
| col_addr | output | 11 | Column of the access |
| col_autopre | output | 1 | Column access closes its bank by itself |

## Verification
If a bank state machine or timer is wrong, the next command to that bank gets the wrong verdict on `cmd_ok`/`cmd_bad`, one cycle after its sampling edge. A slip of the self-close counter also shows up as a change of `bank_open` on the wrong edge. The bench therefore walks each delay edge by edge. It probes one cycle before the limit and exactly at the limit, so an off-by-one in any counter changes a verdict. A stored row that is wrong, or that gets overwritten, is visible directly on `open_row` in the cycle after the activate, or after the rejected command that must not touch it.

// File: rtl/bank_ctl_pkg.sv
package bank_ctl_pkg;

    localparam int BANK_W = 2;
    localparam int ADDR_W = 13;
    localparam int COL_W  = 11;
    localparam int AP_BIT = 10;

    typedef enum logic [2:0] {
        OP_NOP, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS, OP_OTHER
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE, BK_OPEN, BK_CLOSING
    } bank_st_e;

    typedef struct packed {
        op_e                op;
        logic [BANK_W-1:0]  bank;
        logic [ADDR_W-1:0]  addr;
    } cmd_t;

    // pins ordered {cs_n, ras_n, cas_n, we_n}
    function automatic op_e decode_op(input logic [3:0] pins);
        if (pins[3]) return OP_NOP;
        case (pins[2:0])
            3'b011:  return OP_ACT;
            3'b101:  return OP_RD;
            3'b100:  return OP_WR;
            3'b010:  return OP_PRE;
            3'b111:  return OP_NOP;
            3'b001:  return OP_REF;
            3'b000:  return OP_MRS;
            default: return OP_OTHER;
        endcase
    endfunction

    // clocks of data for the selected burst (two beats per clock)
    function automatic logic [2:0] burst_clocks(input logic [1:0] sel);
        case (sel)
            2'b11:   return 3'd4;
            2'b10:   return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] column_of(input logic [ADDR_W-1:0] a);
        return {a[11], a[9:0]};
    endfunction

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_ctl_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd
);
    always_comb begin
        cmd.op   = decode_op({cs_n, ras_n, cas_n, we_n});
        cmd.bank = bank;
        cmd.addr = addr;
    end
endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
    import bank_ctl_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int TW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_act,
    input  logic              do_close_after,
    input  logic              do_pre,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [2:0]        burst_clks,
    output bank_st_e          st,
    output logic              ready,
    output logic [ADDR_W-1:0] row_q
);
    logic [TW-1:0] timer;

    assign ready = (timer == '0) && (st != BK_CLOSING);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= BK_IDLE;
            timer <= '0;
            row_q <= '0;
        end else begin
            if (timer != '0) timer <= timer - 1'b1;
            unique case (st)
                BK_IDLE: begin
                    if (do_act) begin
                        st    <= BK_OPEN;
                        row_q <= row_in;
                        timer <= TW'(T_RCD - 1);
                    end
                end
                BK_OPEN: begin
                    if (do_pre) begin
                        st    <= BK_IDLE;
                        timer <= TW'(T_RP - 1);
                    end else if (do_close_after) begin
                        st    <= BK_CLOSING;
                        timer <= TW'(burst_clks - 3'd1);
                    end
                end
                BK_CLOSING: begin
                    if (timer == '0) begin
                        st    <= BK_IDLE;
                        timer <= TW'(T_RP - 1);
                    end
                end
                default: st <= BK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bank_row_ctl.sv
module bank_row_ctl
    import bank_ctl_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [BANK_W-1:0]            bank,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [1:0]                   burst_sel,
    output logic [(1<<BANK_W)-1:0]       bank_open,
    output logic [(1<<BANK_W)*ADDR_W-1:0] open_row,
    output logic                         cmd_ok,
    output logic                         cmd_bad,
    output logic                         col_valid,
    output logic                         col_write,
    output logic [BANK_W-1:0]            col_bank,
    output logic [COL_W-1:0]             col_addr,
    output logic                         col_autopre
);
    localparam int NB   = 1 << BANK_W;
    localparam int TMAX = (T_RCD > T_RP) ? ((T_RCD > 4) ? T_RCD : 4)
                                         : ((T_RP  > 4) ? T_RP  : 4);
    localparam int TW   = $clog2(TMAX + 1);

    cmd_t        cmd;
    bank_st_e    st    [NB];
    logic [NB-1:0] ready;
    logic [NB-1:0] do_act, do_close_after, do_pre;
    logic        legal, bank_cmd, is_col;
    logic [2:0]  bclks;

    assign bclks = burst_clocks(burst_sel);

    bank_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .cmd(cmd)
    );

    always_comb begin
        bank_cmd = 1'b0;
        legal    = 1'b0;
        unique case (cmd.op)
            OP_ACT: begin
                bank_cmd = 1'b1;
                legal    = (st[cmd.bank] == BK_IDLE) && ready[cmd.bank];
            end
            OP_RD, OP_WR: begin
                bank_cmd = 1'b1;
                legal    = (st[cmd.bank] == BK_OPEN) && ready[cmd.bank];
            end
            OP_PRE: begin
                bank_cmd = 1'b1;
                legal    = cmd.addr[AP_BIT] ? (&ready) : ready[cmd.bank];
            end
            default: ;
        endcase
    end

    assign is_col = (cmd.op == OP_RD) || (cmd.op == OP_WR);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        logic [ADDR_W-1:0] row_i;
        assign hit = (cmd.bank == BANK_W'(i));
        assign do_act[i]         = legal && (cmd.op == OP_ACT) && hit;
        assign do_close_after[i] = legal && is_col && cmd.addr[AP_BIT] && hit;
        assign do_pre[i]         = legal && (cmd.op == OP_PRE) && (cmd.addr[AP_BIT] || hit);

        bank_fsm #(.T_RCD(T_RCD), .T_RP(T_RP), .TW(TW)) u_fsm (
            .clk(clk), .rst(rst),
            .do_act(do_act[i]), .do_close_after(do_close_after[i]), .do_pre(do_pre[i]),
            .row_in(cmd.addr), .burst_clks(bclks),
            .st(st[i]), .ready(ready[i]), .row_q(row_i)
        );

        assign bank_open[i] = (st[i] != BK_IDLE);
        assign open_row[i*ADDR_W +: ADDR_W] = row_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ok      <= 1'b0;
            cmd_bad     <= 1'b0;
            col_valid   <= 1'b0;
            col_write   <= 1'b0;
            col_bank    <= '0;
            col_addr    <= '0;
            col_autopre <= 1'b0;
        end else begin
            cmd_ok    <= bank_cmd && legal;
            cmd_bad   <= bank_cmd && !legal;
            col_valid <= is_col && legal;
            if (is_col && legal) begin
                col_write   <= (cmd.op == OP_WR);
                col_bank    <= cmd.bank;
                col_addr    <= column_of(cmd.addr);
                col_autopre <= cmd.addr[AP_BIT];
            end
        end
    end
endmodule

// File: rtl/bank_row_ctl_checker.sv
module bank_row_ctl_checker
    import bank_ctl_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          cs_n,
    input logic                          ras_n,
    input logic                          cas_n,
    input logic                          we_n,
    input logic [BANK_W-1:0]             bank,
    input logic [ADDR_W-1:0]             addr,
    input logic [(1<<BANK_W)-1:0]        bank_open,
    input logic [(1<<BANK_W)*ADDR_W-1:0] open_row,
    input logic                          cmd_ok,
    input logic                          cmd_bad,
    input logic                          col_valid,
    input logic [BANK_W-1:0]             col_bank
);
    logic [3:0]        prev_pins;
    logic [BANK_W-1:0] prev_bank;
    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] row_at_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pins <= 4'b1111;
            prev_bank <= '0;
            prev_addr <= '0;
        end else begin
            prev_pins <= {cs_n, ras_n, cas_n, we_n};
            prev_bank <= bank;
            prev_addr <= addr;
        end
    end

    assign row_at_prev = open_row[int'(prev_bank)*ADDR_W +: ADDR_W];

    p_one_verdict_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ok && cmd_bad));

    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        prev_pins[3] |-> (!cmd_ok && !cmd_bad && !col_valid));

    p_act_latches_row_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && prev_pins == 4'b0011) |-> (bank_open[prev_bank] && row_at_prev == prev_addr));

    p_column_needs_open_r4: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (bank_open[col_bank] && cmd_ok));

    p_close_all_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && prev_pins == 4'b0010 && prev_addr[AP_BIT]) |-> (bank_open == '0));

    p_reject_keeps_rows_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_bad |-> (open_row == $past(open_row)));
endmodule

bind bank_row_ctl bank_row_ctl_checker u_chk (.*);

// File: tb/bank_row_ctl_test.sv
`timescale 1ns/1ps
module bank_row_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank = '0;
    logic [12:0] addr = '0;
    logic [1:0]  burst_sel = 2'b01;
    logic [3:0]  bank_open;
    logic [51:0] open_row;
    logic        cmd_ok, cmd_bad, col_valid, col_write, col_autopre;
    logic [1:0]  col_bank;
    logic [10:0] col_addr;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_PRE = 4'b0010, P_NOP = 4'b0111, P_REF = 4'b0001,
                           P_MRS = 4'b0000;

    always #2 clk = ~clk;

    bank_row_ctl uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .burst_sel(burst_sel),
        .bank_open(bank_open), .open_row(open_row), .cmd_ok(cmd_ok), .cmd_bad(cmd_bad),
        .col_valid(col_valid), .col_write(col_write), .col_bank(col_bank),
        .col_addr(col_addr), .col_autopre(col_autopre)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the sampling edge
    task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = pins;
        bank = b;
        addr = a;
        @(posedge clk);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
    endtask

    task automatic verdict(input string req, input logic ok, input logic bad);
        check(req, "cmd_ok", 64'(cmd_ok), 64'(ok));
        check(req, "cmd_bad", 64'(cmd_bad), 64'(bad));
    endtask

    function automatic logic [12:0] row_of(input int b);
        return open_row[b*13 +: 13];
    endfunction

    task automatic t_reset;
        check("R1", "bank_open", 64'(bank_open), 64'h0);
        check("R1", "open_row", 64'(open_row), 64'h0);
        check("R1", "flags", 64'({cmd_ok, cmd_bad, col_valid}), 64'h0);
    endtask

    task automatic t_activate_and_rcd;
        issue(P_ACT, 2'd1, 13'h1ABC);
        verdict("R3", 1'b1, 1'b0);
        check("R3", "bank_open", 64'(bank_open), 64'h2);
        check("R3", "row b1", 64'(row_of(1)), 64'h1ABC);
        issue(P_RD, 2'd1, 13'h0155);
        verdict("R7", 1'b0, 1'b1);
        check("R7", "col_valid early", 64'(col_valid), 64'h0);
        issue(P_RD, 2'd1, 13'h0155);
        verdict("R7", 1'b0, 1'b1);
        issue(P_RD, 2'd1, 13'h0155);
        verdict("R7", 1'b1, 1'b0);
        check("R4", "read col", 64'({col_valid, col_write, col_bank, col_autopre, col_addr}),
              64'({1'b1, 1'b0, 2'd1, 1'b0, 11'h155}));
    endtask

    task automatic t_deselect;
        issue(4'b1011, 2'd2, 13'h0777);
        verdict("R2", 1'b0, 1'b0);
        check("R2", "bank_open", 64'(bank_open), 64'h2);
        check("R2", "row b2", 64'(row_of(2)), 64'h0);
    endtask

    task automatic t_rejects;
        issue(P_RD, 2'd3, 13'h0001);
        verdict("R10", 1'b0, 1'b1);
        check("R10", "col_valid closed", 64'(col_valid), 64'h0);
        issue(P_ACT, 2'd1, 13'h0042);
        verdict("R10", 1'b0, 1'b1);
        check("R10", "row b1 kept", 64'(row_of(1)), 64'h1ABC);
        check("R10", "bank_open", 64'(bank_open), 64'h2);
    endtask

    task automatic t_write;
        issue(P_WR, 2'd1, 13'h0AAA);   // A11=1, A10=0, low bits 2AA
        verdict("R4", 1'b1, 1'b0);
        check("R4", "write col", 64'({col_valid, col_write, col_bank, col_autopre, col_addr}),
              64'({1'b1, 1'b1, 2'd1, 1'b0, 11'h6AA}));
    endtask

    task automatic t_pre_single_and_rp;
        issue(P_ACT, 2'd0, 13'h0007);
        verdict("R3", 1'b1, 1'b0);
        issue(P_PRE, 2'd1, 13'h0000);
        verdict("R6", 1'b1, 1'b0);
        check("R6", "only b1 closed", 64'(bank_open), 64'h1);
        issue(P_ACT, 2'd1, 13'h0123);
        verdict("R8", 1'b0, 1'b1);
        issue(P_ACT, 2'd1, 13'h0123);
        verdict("R8", 1'b0, 1'b1);
        issue(P_ACT, 2'd1, 13'h0123);
        verdict("R8", 1'b1, 1'b0);
        check("R8", "row b1", 64'(row_of(1)), 64'h0123);
    endtask

    task automatic t_pre_all;
        issue(P_PRE, 2'd3, 13'h0400);   // b1 timer still running
        verdict("R10", 1'b0, 1'b1);
        check("R10", "bank_open kept", 64'(bank_open), 64'h3);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_PRE, 2'd3, 13'h0400);
        verdict("R5", 1'b1, 1'b0);
        check("R5", "all closed", 64'(bank_open), 64'h0);
    endtask

    task automatic t_autoclose_long;
        burst_sel = 2'b11;
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_ACT, 2'd2, 13'h0F0F);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_RD, 2'd2, 13'h0405);
        verdict("R9", 1'b1, 1'b0);
        check("R9", "autopre flag", 64'({col_valid, col_autopre, col_addr}), 64'({1'b1, 1'b1, 11'h005}));
        issue(P_RD, 2'd2, 13'h0001);
        verdict("R10", 1'b0, 1'b1);
        check("R9", "open +1", 64'(bank_open[2]), 64'h1);
        issue(P_NOP, 2'd0, 13'h0);
        check("R9", "open +2", 64'(bank_open[2]), 64'h1);
        issue(P_NOP, 2'd0, 13'h0);
        check("R9", "open +3", 64'(bank_open[2]), 64'h1);
        issue(P_NOP, 2'd0, 13'h0);
        check("R9", "closed +4", 64'(bank_open[2]), 64'h0);
        issue(P_ACT, 2'd2, 13'h0003);
        verdict("R9", 1'b0, 1'b1);
        issue(P_ACT, 2'd2, 13'h0003);
        verdict("R9", 1'b0, 1'b1);
        issue(P_ACT, 2'd2, 13'h0003);
        verdict("R9", 1'b1, 1'b0);
    endtask

    task automatic t_autoclose_short;
        burst_sel = 2'b01;
        issue(P_ACT, 2'd3, 13'h1111);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_NOP, 2'd0, 13'h0);
        issue(P_WR, 2'd3, 13'h0400);
        verdict("R9", 1'b1, 1'b0);
        check("R9", "short open +0", 64'(bank_open[3]), 64'h1);
        issue(P_NOP, 2'd0, 13'h0);
        check("R9", "short closed +1", 64'(bank_open[3]), 64'h0);
        check("R9", "b2 untouched", 64'(bank_open[2]), 64'h1);
    endtask

    task automatic t_other_cmds;
        issue(P_REF, 2'd0, 13'h0);
        verdict("R11", 1'b0, 1'b0);
        issue(P_MRS, 2'd0, 13'h0033);
        verdict("R11", 1'b0, 1'b0);
        check("R11", "bank_open", 64'(bank_open), 64'h4);
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_activate_and_rcd();
        t_deselect();
        t_rejects();
        t_write();
        t_pre_single_and_rp();
        t_pre_all();
        t_autoclose_long();
        t_autoclose_short();
        t_other_cmds();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule